// File: doc/BRIEF.md
# Byte ALU with Program Flags Register

This block is the arithmetic and logic datapath of a small eight-bit controller. It takes a destination byte, a source byte and a five-bit operation select. It presents the result combinationally, with a write-enable for the destination. On the clock edge where the update strobe is high, it merges a fresh set of condition flags into a clocked flags byte. Each operation owns its own subset of the six condition flags. Some of those flags it computes, some it forces, and the rest it leaves as they were. Compare, test and test-complement produce only flags and never ask for a result write. The carry commands touch the carry bit and nothing else.

The flags byte also behaves as an ordinary register. It can be read at any time on its output port, and a direct byte write replaces it. When a direct write and an ALU update land in the same cycle, the direct write wins. The two lowest bits are user flags that no ALU operation changes.

Top module: `byte_alu`

## Requirements
- R1: Reset is synchronous and active low and clears the flags byte to 0x00. The flags byte holds carry in bit 7, zero in bit 6, sign in bit 5, overflow in bit 4, decimal-adjust in bit 3, half-carry in bit 2, and the two user flags in bits 1 and 0.
- R2: Opcode 0x00 (add) and 0x01 (add with carry-in C) write d+s(+C). C is the carry out of bit 7 and H is the carry out of bit 3. V is set when the operands share a sign that the result lacks. Z and S follow the result, and D is cleared.
- R3: Opcode 0x02 (subtract) and 0x03 (subtract with borrow C) write d-s(-C). C is the borrow out of bit 7 and H is the borrow out of bit 3. V is set when the operand signs differ and the result sign differs from d. Z and S follow the result, and D is set to 1.
- R4: Opcode 0x0A (compare) forms d-s. It sets C, Z, S and V as a subtraction would, keeps D and H, and does not assert the write-enable.
- R5: Opcodes 0x04 (OR), 0x05 (AND), 0x0B (XOR) and 0x13 (one's complement of d) write their result. They set Z and S from the result, clear V, and keep C, D and H.
- R6: Opcodes 0x07 (test, d AND s) and 0x06 (test-complement, NOT d AND s) set Z and S from that value and clear V. They keep C, D and H, and never assert the write-enable.
- R7: Opcodes 0x10 (increment) and 0x11 (decrement) write d±1. They set Z and S, and set V on a signed overflow (0x7F up, 0x80 down). They keep C, D and H. Opcode 0x12 (clear) writes 0x00 and changes no flag.
- R8: Opcodes 0x14 (rotate left, bit 7 to bit 0), 0x15 (rotate left through C), 0x16 (rotate right, bit 0 to bit 7) and 0x17 (rotate right through C) load C with the bit shifted out. They set Z and S, set V when bit 7 changed, and keep D and H.
- R9: Opcode 0x18 (arithmetic shift right) keeps bit 7, moves bit 0 into C, sets Z and S, clears V, and keeps D and H.
- R10: Opcode 0x19 (nibble swap) exchanges the two halves of d. It sets Z and S, forces C and V to 0, and keeps D and H.
- R11: Opcode 0x1A (decimal adjust) corrects d to BCD and sets C, Z and S, keeping V, D and H. When D=0 it adds 0x60 if C=1 or d>0x99, setting C in that case, and adds 0x06 if H=1 or the low nibble is above 9. When D=1 it subtracts 0x60 if C=1 and 0x06 if H=1, and C is kept.
- R12: Opcodes 0x1B, 0x1C and 0x1D invert, set and clear C respectively. They assert no write and change no other flag.
- R13: A direct flags write replaces the whole byte and wins over a same-cycle update. With neither strobe high the flags hold, and no ALU operation changes bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 5 | Operation select (codes in the requirements) |
| dst | input | 8 | Destination operand |
| src | input | 8 | Source operand |
| upd | input | 1 | Execute strobe: commits flags and qualifies the write-enable |
| res | output | 8 | Result byte (combinational) |
| res_we | output | 1 | Destination write-enable |
| fl_we | input | 1 | Direct write strobe for the flags byte |
| fl_wdata | input | 8 | Direct write data for the flags byte |
| flags | output | 8 | Current flags byte |

## Verification
The bench builds the block with its package defaults, an eight-bit datapath and four-bit nibbles. At that size every operand pair is reachable, and so are the half-carry and BCD boundaries at 9/0x99. Random direct flag writes seed every C, D and H combination ahead of decimal adjust, the carry-in operations and the rotates through carry. Directed vectors cover the signed overflow edges 0x7F/0x80, the zero results, and a BCD add and subtract followed by adjust. They also cover a direct write that collides with an update.

// File: rtl/byte_alu_pkg.sv
// Shared widths, flag bit positions and operation codes for the byte ALU.
// Assumes an eight-bit datapath split into two four-bit nibbles.
package byte_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int FW = 8;

    localparam int FC = 7;
    localparam int FZ = 6;
    localparam int FS = 5;
    localparam int FV = 4;
    localparam int FD = 3;
    localparam int FH = 2;

    localparam logic [DW-1:0] BCD_HI  = 8'h60;
    localparam logic [DW-1:0] BCD_LO  = 8'h06;
    localparam logic [DW-1:0] BCD_MAX = 8'h99;
    localparam logic [NW-1:0] NIB_MAX = 4'h9;

    localparam logic [4:0] OP_ADD   = 5'h00;
    localparam logic [4:0] OP_ADC   = 5'h01;
    localparam logic [4:0] OP_SUB   = 5'h02;
    localparam logic [4:0] OP_SBC   = 5'h03;
    localparam logic [4:0] OP_OR    = 5'h04;
    localparam logic [4:0] OP_AND   = 5'h05;
    localparam logic [4:0] OP_TCM   = 5'h06;
    localparam logic [4:0] OP_TM    = 5'h07;
    localparam logic [4:0] OP_CP    = 5'h0A;
    localparam logic [4:0] OP_XOR   = 5'h0B;
    localparam logic [4:0] OP_INC   = 5'h10;
    localparam logic [4:0] OP_DEC   = 5'h11;
    localparam logic [4:0] OP_CLR   = 5'h12;
    localparam logic [4:0] OP_COM   = 5'h13;
    localparam logic [4:0] OP_ROTL  = 5'h14;
    localparam logic [4:0] OP_ROTLC = 5'h15;
    localparam logic [4:0] OP_ROTR  = 5'h16;
    localparam logic [4:0] OP_ROTRC = 5'h17;
    localparam logic [4:0] OP_SRA   = 5'h18;
    localparam logic [4:0] OP_SWAP  = 5'h19;
    localparam logic [4:0] OP_DAJ   = 5'h1A;
    localparam logic [4:0] OP_CCF   = 5'h1B;
    localparam logic [4:0] OP_SCF   = 5'h1C;
    localparam logic [4:0] OP_RCF   = 5'h1D;
endpackage

// File: rtl/byte_alu_addsub.sv
// Adder/subtractor shared by add, subtract, compare, increment, decrement.
// Produces the result with carry/borrow out of the top bit and of the low
// nibble, plus signed overflow. Purely combinational.
module byte_alu_addsub
    import byte_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] r,
    output logic          c,
    output logic          h,
    output logic          v
);
    logic [DW:0] wide;
    logic [NW:0] half;

    // Full-width and low-nibble sums or differences; the extra bit is carry/borrow.
    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            half = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            half = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end
    end

    // Result, carries and signed overflow by operand and result signs.
    always_comb begin
        r = wide[DW-1:0];
        c = wide[DW];
        h = half[NW];
        if (sub)
            v = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
        else
            v = (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/byte_alu_shift.sv
// Single-operand bit manipulation: complement, rotates, arithmetic shift,
// nibble swap and decimal adjust. Assumes the caller supplies the current
// C, D and H flags. Purely combinational; unrelated codes pass d through.
module byte_alu_shift
    import byte_alu_pkg::*;
(
    input  logic [4:0]    op,
    input  logic [DW-1:0] d,
    input  logic          cf,
    input  logic          df,
    input  logic          hf,
    output logic [DW-1:0] r,
    output logic          c
);
    logic          fix_hi;
    logic          fix_lo;
    logic [DW-1:0] adj;

    // Decimal-adjust correction term chosen by the direction flag D.
    always_comb begin
        if (!df) begin
            fix_hi = cf || (d > BCD_MAX);
            fix_lo = hf || (d[NW-1:0] > NIB_MAX);
        end else begin
            fix_hi = cf;
            fix_lo = hf;
        end
        adj = (fix_hi ? BCD_HI : '0) | (fix_lo ? BCD_LO : '0);
    end

    // Per-operation result and outgoing carry.
    always_comb begin
        r = d;
        c = cf;
        case (op)
            OP_COM:   r = ~d;
            OP_ROTL:  begin r = {d[DW-2:0], d[DW-1]}; c = d[DW-1]; end
            OP_ROTLC: begin r = {d[DW-2:0], cf};      c = d[DW-1]; end
            OP_ROTR:  begin r = {d[0], d[DW-1:1]};    c = d[0];    end
            OP_ROTRC: begin r = {cf, d[DW-1:1]};      c = d[0];    end
            OP_SRA:   begin r = {d[DW-1], d[DW-1:1]}; c = d[0];    end
            OP_SWAP:  begin r = {d[NW-1:0], d[DW-1:NW]}; c = 1'b0; end
            OP_DAJ: begin
                r = df ? (d - adj) : (d + adj);
                c = df ? cf : fix_hi;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/byte_alu_flagreg.sv
// Clocked flags byte. A direct write beats an ALU update; an ALU update
// changes only the bits its mask selects. Synchronous active-low reset to 0.
module byte_alu_flagreg
    import byte_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_en,
    input  logic [FW-1:0] fw_data,
    input  logic          upd,
    input  logic [FW-1:0] mask,
    input  logic [FW-1:0] nf,
    output logic [FW-1:0] q
);
    for (genvar i = 0; i < FW; i++) begin : g_bit
        // One flag bit: reset, direct write, or masked update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (fw_en)
                q[i] <= fw_data[i];
            else if (upd && mask[i])
                q[i] <= nf[i];
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> q == '0);
    a_r13_direct_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fw_en |=> q == $past(fw_data));
    a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fw_en && !upd) |=> $stable(q));
endmodule

// File: rtl/byte_alu.sv
// Byte ALU top: decodes the operation, routes operands to the add/sub and
// bit-manipulation units, forms the result, write-enable and per-operation
// flag mask, and owns the flags register. Assumes op codes from the package.
module byte_alu
    import byte_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    op,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic          upd,
    output logic [DW-1:0] res,
    output logic          res_we,
    input  logic          fl_we,
    input  logic [FW-1:0] fl_wdata,
    output logic [FW-1:0] flags
);
    logic [DW-1:0] as_b, as_r, bo_r, r;
    logic          as_cin, as_sub, as_c, as_h, as_v, bo_c, we_op;
    logic [FW-1:0] mask, nf;

    // Operand routing for the adder/subtractor.
    always_comb begin
        as_b   = src;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = flags[FC];
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = flags[FC]; end
            OP_INC: as_b = DW'(1);
            OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    byte_alu_addsub u_addsub (
        .a(dst), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .c(as_c), .h(as_h), .v(as_v)
    );

    byte_alu_shift u_shift (
        .op(op), .d(dst), .cf(flags[FC]), .df(flags[FD]), .hf(flags[FH]),
        .r(bo_r), .c(bo_c)
    );

    // Result, write-enable, new flag values and the mask of flags each op owns.
    always_comb begin
        r     = dst;
        we_op = 1'b0;
        mask  = '0;
        nf    = flags;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                r = as_r; we_op = 1'b1;
                mask = FW'((1 << FC) | (1 << FZ) | (1 << FS) | (1 << FV) | (1 << FD) | (1 << FH));
                nf[FC] = as_c; nf[FV] = as_v; nf[FH] = as_h; nf[FD] = as_sub;
            end
            OP_CP: begin
                r = as_r;
                mask = FW'((1 << FC) | (1 << FZ) | (1 << FS) | (1 << FV));
                nf[FC] = as_c; nf[FV] = as_v;
            end
            OP_OR, OP_AND, OP_XOR, OP_COM, OP_TM, OP_TCM: begin
                case (op)
                    OP_OR:   r = dst | src;
                    OP_AND:  r = dst & src;
                    OP_XOR:  r = dst ^ src;
                    OP_TM:   r = dst & src;
                    OP_TCM:  r = ~dst & src;
                    default: r = bo_r;
                endcase
                we_op = (op != OP_TM) && (op != OP_TCM);
                mask = FW'((1 << FZ) | (1 << FS) | (1 << FV));
                nf[FV] = 1'b0;
            end
            OP_INC, OP_DEC: begin
                r = as_r; we_op = 1'b1;
                mask = FW'((1 << FZ) | (1 << FS) | (1 << FV));
                nf[FV] = as_v;
            end
            OP_CLR: begin r = '0; we_op = 1'b1; end
            OP_ROTL, OP_ROTLC, OP_ROTR, OP_ROTRC, OP_SRA, OP_SWAP: begin
                r = bo_r; we_op = 1'b1;
                mask = FW'((1 << FC) | (1 << FZ) | (1 << FS) | (1 << FV));
                nf[FC] = bo_c;
                nf[FV] = (op == OP_SRA || op == OP_SWAP) ? 1'b0 : (bo_r[DW-1] ^ dst[DW-1]);
            end
            OP_DAJ: begin
                r = bo_r; we_op = 1'b1;
                mask = FW'((1 << FC) | (1 << FZ) | (1 << FS));
                nf[FC] = bo_c;
            end
            OP_CCF: begin mask = FW'(1 << FC); nf[FC] = ~flags[FC]; end
            OP_SCF: begin mask = FW'(1 << FC); nf[FC] = 1'b1; end
            OP_RCF: begin mask = FW'(1 << FC); nf[FC] = 1'b0; end
            default: ;
        endcase
        nf[FZ] = (r == '0);
        nf[FS] = r[DW-1];
    end

    assign res    = r;
    assign res_we = upd && we_op;

    byte_alu_flagreg u_flags (
        .clk(clk), .rst_n(rst_n), .fw_en(fl_we), .fw_data(fl_wdata),
        .upd(upd), .mask(mask), .nf(nf), .q(flags)
    );

    a_r12_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !fl_we && (op == OP_CCF || op == OP_SCF || op == OP_RCF))
        |=> flags[FC-1:0] == $past(flags[FC-1:0]));
    a_r5_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !fl_we && (op == OP_OR || op == OP_AND || op == OP_XOR || op == OP_COM))
        |=> !flags[FV] && flags[FC] == $past(flags[FC]));
    a_r10_swap_zero_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !fl_we && op == OP_SWAP) |=> !flags[FC] && !flags[FV]);
    a_r3_sub_sets_d: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !fl_we && (op == OP_SUB || op == OP_SBC)) |=> flags[FD]);
    a_r13_user_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !fl_we) |=> flags[1:0] == $past(flags[1:0]));
    a_r6_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TM || op == OP_TCM || op == OP_CP) |-> !res_we);
endmodule

// File: tb/byte_alu_bench.sv
`timescale 1ns/100ps
module byte_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] dst = '0, src = '0, fl_wdata = '0;
    logic       upd = 1'b0, fl_we = 1'b0;
    logic [7:0] res, flags;
    logic       res_we;

    int         n_chk = 0, n_bad = 0;
    logic [7:0] ef = '0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    byte_alu u_byte_alu (
        .clk(clk), .rst_n(rst_n), .op(op), .dst(dst), .src(src), .upd(upd),
        .res(res), .res_we(res_we), .fl_we(fl_we), .fl_wdata(fl_wdata), .flags(flags)
    );

    localparam logic [4:0] LEGAL [24] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05,
        5'h06, 5'h07, 5'h0A, 5'h0B, 5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15,
        5'h16, 5'h17, 5'h18, 5'h19, 5'h1A, 5'h1B, 5'h1C, 5'h1D};

    function automatic string tag_of(logic [4:0] o);
        case (o)
            5'h00, 5'h01: return "R2";
            5'h02, 5'h03: return "R3";
            5'h0A: return "R4";
            5'h04, 5'h05, 5'h0B, 5'h13: return "R5";
            5'h06, 5'h07: return "R6";
            5'h10, 5'h11, 5'h12: return "R7";
            5'h14, 5'h15, 5'h16, 5'h17: return "R8";
            5'h18: return "R9";
            5'h19: return "R10";
            5'h1A: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Reference model: returns {write, result, new flags}.
    function automatic logic [16:0] model(logic [4:0] o, logic [7:0] d, logic [7:0] s, logic [7:0] f);
        int t, ci, lo, adj;
        logic [7:0] r, n;
        logic w, zs;
        n = f; r = d; w = 1'b0; zs = 1'b1;
        ci = ((o == 5'h01 || o == 5'h03) && f[7]) ? 1 : 0;
        case (o)
            5'h00, 5'h01: begin
                t = int'(d) + int'(s) + ci; r = 8'(t); w = 1'b1;
                lo = int'(d[3:0]) + int'(s[3:0]) + ci;
                n[7] = t > 255; n[2] = lo > 15; n[3] = 1'b0;
                n[4] = (d[7] == s[7]) && (r[7] != d[7]);
            end
            5'h02, 5'h03, 5'h0A: begin
                t = int'(d) - int'(s) - ci; r = 8'(t);
                lo = int'(d[3:0]) - int'(s[3:0]) - ci;
                n[7] = t < 0; n[4] = (d[7] != s[7]) && (r[7] != d[7]);
                if (o != 5'h0A) begin w = 1'b1; n[2] = lo < 0; n[3] = 1'b1; end
            end
            5'h04: begin r = d | s; w = 1'b1; n[4] = 1'b0; end
            5'h05: begin r = d & s; w = 1'b1; n[4] = 1'b0; end
            5'h0B: begin r = d ^ s; w = 1'b1; n[4] = 1'b0; end
            5'h13: begin r = ~d;    w = 1'b1; n[4] = 1'b0; end
            5'h07: begin r = d & s;  n[4] = 1'b0; end
            5'h06: begin r = ~d & s; n[4] = 1'b0; end
            5'h10: begin r = d + 8'd1; w = 1'b1; n[4] = (d == 8'h7F); end
            5'h11: begin r = d - 8'd1; w = 1'b1; n[4] = (d == 8'h80); end
            5'h12: begin r = 8'h00; w = 1'b1; zs = 1'b0; end
            5'h14, 5'h15, 5'h16, 5'h17: begin
                w = 1'b1;
                if (o == 5'h14) r = {d[6:0], d[7]};
                if (o == 5'h15) r = {d[6:0], f[7]};
                if (o == 5'h16) r = {d[0], d[7:1]};
                if (o == 5'h17) r = {f[7], d[7:1]};
                n[7] = (o < 5'h16) ? d[7] : d[0];
                n[4] = r[7] ^ d[7];
            end
            5'h18: begin r = {d[7], d[7:1]}; w = 1'b1; n[7] = d[0]; n[4] = 1'b0; end
            5'h19: begin r = {d[3:0], d[7:4]}; w = 1'b1; n[7] = 1'b0; n[4] = 1'b0; end
            5'h1A: begin
                w = 1'b1; adj = 0;
                if (!f[3]) begin
                    if (f[7] || d > 8'h99) begin adj = adj + 96; n[7] = 1'b1; end
                    if (f[2] || d[3:0] > 4'h9) adj = adj + 6;
                    r = 8'(int'(d) + adj);
                end else begin
                    if (f[7]) adj = adj + 96;
                    if (f[2]) adj = adj + 6;
                    r = 8'(int'(d) - adj);
                end
            end
            5'h1B: begin n[7] = ~f[7]; zs = 1'b0; end
            5'h1C: begin n[7] = 1'b1;  zs = 1'b0; end
            default: begin n[7] = 1'b0; zs = 1'b0; end
        endcase
        if (zs) begin n[6] = (r == 8'h00); n[5] = r[7]; end
        return {w, r, n};
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check result, clock, check flags.
    task automatic step(logic [4:0] o, logic [7:0] d, logic [7:0] s, logic u,
                        logic fw, logic [7:0] fwd, string tag);
        logic [16:0] m;
        @(negedge clk);
        op = o; dst = d; src = s; upd = u; fl_we = fw; fl_wdata = fwd;
        #1;
        m = model(o, d, s, ef);
        check(tag, "result", res, m[15:8]);
        check(tag, "write-enable", {7'd0, res_we}, {7'd0, u & m[16]});
        @(posedge clk);
        #1;
        if (fw) ef = fwd;
        else if (u) ef = m[7:0];
        check(tag, "flags", flags, ef);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BAD5EED));
        repeat (3) @(posedge clk);
        #1 check("R1", "reset flags", flags, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        // R2 directed: signed overflow with half carry, then wrap to zero.
        step(5'h00, 8'h7F, 8'h01, 1'b1, 1'b0, 8'h00, "R2");
        step(5'h00, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h00, "R2");
        step(5'h01, 8'h10, 8'h20, 1'b1, 1'b0, 8'h00, "R2");
        // R3 directed: borrow, and signed overflow 0x80-1.
        step(5'h02, 8'h00, 8'h01, 1'b1, 1'b0, 8'h00, "R3");
        step(5'h03, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, "R3");
        // R4 compare equal: Z set, no write.
        step(5'h0A, 8'h55, 8'h55, 1'b1, 1'b0, 8'h00, "R4");
        // R6 test and test-complement.
        step(5'h07, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, "R6");
        step(5'h06, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, "R6");
        // R7 increment/decrement overflow edges and clear.
        step(5'h10, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h00, "R7");
        step(5'h11, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, "R7");
        step(5'h12, 8'hA5, 8'h00, 1'b1, 1'b0, 8'h00, "R7");
        // R11 BCD add 15+27 then adjust to 42; subtract 42-15 then adjust to 27.
        step(5'h00, 8'h15, 8'h27, 1'b1, 1'b0, 8'h00, "R11");
        step(5'h1A, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h00, "R11");
        check("R11", "bcd sum", res, 8'h42);
        step(5'h02, 8'h42, 8'h15, 1'b1, 1'b0, 8'h00, "R11");
        step(5'h1A, 8'h2D, 8'h00, 1'b1, 1'b0, 8'h00, "R11");
        check("R11", "bcd difference", res, 8'h27);
        // R10 swap and R12 carry commands on all-set flags.
        step(5'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, "R13");
        step(5'h19, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h00, "R10");
        step(5'h1C, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, "R12");
        step(5'h1B, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, "R12");
        step(5'h1D, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, "R12");
        // R13 direct write collides with update; idle hold.
        step(5'h00, 8'hFF, 8'h01, 1'b1, 1'b1, 8'h03, "R13");
        check("R13", "collision", flags, 8'h03);
        step(5'h02, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, "R13");
        // R8/R9 rotates and shift through a known carry.
        step(5'h15, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, "R8");
        step(5'h17, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, "R8");
        step(5'h18, 8'h81, 8'h00, 1'b1, 1'b0, 8'h00, "R9");
        // Random mix; occasional direct writes seed C, D, H and the user bits.
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] o;
            o = LEGAL[$urandom_range(0, 23)];
            if ($urandom_range(0, 7) == 0)
                step(o, 8'($urandom), 8'($urandom), 1'($urandom), 1'b1, 8'($urandom), "R13");
            else
                step(o, 8'($urandom), 8'($urandom), ($urandom_range(0, 7) != 0), 1'b0, 8'h00, tag_of(o));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule